// File: doc/BRIEF.md
# Instruction Field Decoder

This block sits in the decode stage of a small 32-bit load/store processor. It takes one 32-bit instruction word per clock and splits it into register specifiers, a shift amount, a 26-bit jump target and an extended 32-bit immediate. It also derives the control bundle that the rest of the pipeline consumes: an ALU operation code, the destination register and its write enable, memory read and write strobes with access size and signedness, and branch, jump and link flags.

The word is classified by its 6-bit opcode. The register-register format selects its operation with a separate 6-bit function field. The register-immediate format carries a 16-bit immediate. The jump format carries a 26-bit target. The destination comes from the rd field, the rt field or the fixed link register 31, depending on the operation. Register 0 is never written. Any word outside the supported subset raises an illegal flag and leaves every strobe low.

All decoded outputs are registered once, so an instruction presented before a rising edge appears on the outputs after that edge. The register file, ALU and memory are outside the block.

Top module: `instr_decode`

## Requirements
- R1: While rst_n is low at a rising edge, every output is zero after that edge. Otherwise the outputs after each rising edge are the decode of the instr value sampled at that edge, which gives one cycle of latency.
- R2: For every word, rs = instr[25:21], rt = instr[20:16], shamt = instr[10:6] and target = instr[25:0], whether or not the word is legal.
- R3: fmt is 0 (register format) for opcode 000000, 2 (jump format) for opcodes 000010 and 000011, and 1 (immediate format) for every other opcode.
- R4: With opcode 000000, these function codes write rd with alu_src_imm = 0 and the following alu_op values (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 nor, 6 slt, 7 sltu): 100000 and 100001 give 0; 100010 and 100011 give 1; 100100 gives 2; 100101 gives 3; 100110 gives 4; 100111 gives 5; 101010 gives 6; 101011 gives 7.
- R5: With opcode 000000, the shifts write rd. Function codes 000000, 000010 and 000011 give alu_op 8 (left logical), 9 (right logical) and 10 (right arithmetic) with shift_var = 0. Function codes 000100, 000110 and 000111 give the same three codes with shift_var = 1.
- R6: imm is instr[15:0] zero-extended for opcodes 001100, 001101 and 001110. It is instr[15:0] followed by 16 zero bits for opcode 001111. For every other word it is instr[15:0] sign-extended.
- R7: Immediate ALU opcodes write rt with alu_src_imm = 1. The alu_op values are: 001000 and 001001 give 0; 001010 gives 6; 001011 gives 7; 001100 gives 2; 001101 gives 3; 001110 gives 4; 001111 gives 11 (pass operand B).
- R8: Loads (100000 byte signed, 100001 half signed, 100011 word, 100100 byte unsigned, 100101 half unsigned) assert mem_rd and write rt. Stores (101000 byte, 101001 half, 101011 word) assert mem_wr and write nothing. Both use alu_op 0 and alu_src_imm = 1. mem_size is 0 for byte, 1 for half and 2 for word. mem_unsigned is 1 only for the two unsigned loads.
- R9: Opcodes 000100, 000101, 000110 and 000111 assert is_branch with br_cond 0 (equal), 1 (not equal), 2 (less than or equal to zero) and 3 (greater than zero) respectively. They use alu_op 1 and write no register.
- R10: Opcode 000010 asserts is_jump. Opcode 000011 asserts is_jump and link and writes register 31. Opcode 000000 with function 001000 asserts is_jump and jump_reg and writes no register. All three use alu_op 0.
- R11: When the selected destination register is 0, reg_we is 0. dest reads 0 whenever reg_we is 0.
- R12: Any other opcode, and any other function code under opcode 000000, asserts illegal. In that case reg_we, mem_rd, mem_wr, is_branch, is_jump, jump_reg, link, alu_src_imm and shift_var are 0 and alu_op, mem_size, mem_unsigned and br_cond are 0. Those same control outputs are 0 for every legal word that does not call for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr | input | 32 | Instruction word to decode |
| rs | output | 5 | First source register field |
| rt | output | 5 | Second source / target register field |
| shamt | output | 5 | Constant shift amount field |
| target | output | 26 | Jump target field |
| imm | output | 32 | Extended immediate |
| fmt | output | 2 | Format class: 0 register, 1 immediate, 2 jump |
| dest | output | 5 | Destination register, 0 when no write |
| reg_we | output | 1 | Register write enable |
| alu_op | output | 4 | ALU operation code |
| alu_src_imm | output | 1 | ALU operand B is the immediate |
| shift_var | output | 1 | Shift amount comes from a register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_size | output | 2 | Access size: 0 byte, 1 half, 2 word |
| mem_unsigned | output | 1 | Load is zero-extended |
| is_branch | output | 1 | Conditional branch |
| br_cond | output | 2 | Branch condition code |
| is_jump | output | 1 | Unconditional jump |
| jump_reg | output | 1 | Jump target comes from a register |
| link | output | 1 | Return address goes to register 31 |
| illegal | output | 1 | Word outside the supported subset |

## Verification
The bench sweeps all 64 opcodes and, under opcode 000000, all 64 function codes. Each code is tried with four field patterns. One pattern sets rt to zero, one sets rd to zero, and the immediate sign bit alternates, so the same opcode is seen both writing and suppressed, and with sign- and zero-extension told apart. The illegal codes fill the gaps between legal ones, so each sweep also separates neighbouring encodings that differ by a single bit. Field extraction, format class, immediate and the control bundle are compared separately for each word, so a fault shows up against the requirement it breaks.

// File: rtl/idec_pkg.sv
// Shared widths, codes and the control bundle of the instruction decoder.
// Assumes 32-bit words with a 6-bit opcode at the top of every format.
package idec_pkg;
    localparam int IW     = 32;
    localparam int OPW    = 6;
    localparam int RW     = 5;
    localparam int IMMW   = 16;
    localparam int TGTW   = 26;
    localparam int ALUW   = 4;
    localparam logic [RW-1:0]  LINK_REG = RW'(31);
    localparam logic [OPW-1:0] OP_REG   = '0;

    typedef enum logic [ALUW-1:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SLTU,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {FMT_R, FMT_I, FMT_J} fmt_e;
    typedef enum logic [1:0] {DST_NONE, DST_RD, DST_RT, DST_LINK} dsel_e;
    typedef enum logic [1:0] {IMM_SIGN, IMM_ZERO, IMM_UPPER} imm_e;

    typedef struct packed {
        logic    legal;
        logic    we;
        dsel_e   dsel;
        alu_op_e alu_op;
        logic    src_imm;
        logic    shift_var;
        logic    mem_rd;
        logic    mem_wr;
        logic [1:0] msize;
        logic    munsigned;
        logic    branch;
        logic [1:0] bcond;
        logic    jump;
        logic    jreg;
        logic    link;
    } ctl_t;

    // All strobes low, add operation, not legal.
    function automatic ctl_t ctl_idle();
        ctl_t c;
        c = '0;
        return c;
    endfunction
endpackage

// File: rtl/idec_imm.sv
// Extends the 16-bit immediate field to a full word.
// Assumes IW is twice IMMW so the upper placement fills the word exactly.
module idec_imm
    import idec_pkg::*;
(
    input  logic [IMMW-1:0] raw,
    input  imm_e            mode,
    output logic [IW-1:0]   ext
);
    localparam int PADW = IW - IMMW;

    // Pick zero, sign or upper-half placement of the raw field.
    always_comb begin
        case (mode)
            IMM_ZERO:  ext = {{PADW{1'b0}}, raw};
            IMM_UPPER: ext = {raw, {PADW{1'b0}}};
            default:   ext = {{PADW{raw[IMMW-1]}}, raw};
        endcase
    end
endmodule

// File: rtl/idec_opc.sv
// Decodes every non-register-format opcode into the control bundle and
// the immediate extension mode. Opcode 000000 returns an idle bundle; the
// function decoder handles it.
module idec_opc
    import idec_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output ctl_t           ctl,
    output imm_e           imode
);
    // Opcode lookup for jumps, branches, immediate ALU and memory access.
    always_comb begin
        ctl   = ctl_idle();
        imode = IMM_SIGN;
        case (opcode)
            6'b000010: begin ctl.legal = 1'b1; ctl.jump = 1'b1; end
            6'b000011: begin
                ctl.legal = 1'b1; ctl.jump = 1'b1; ctl.link = 1'b1;
                ctl.we = 1'b1; ctl.dsel = DST_LINK;
            end
            6'b000100, 6'b000101, 6'b000110, 6'b000111: begin
                ctl.legal  = 1'b1;
                ctl.branch = 1'b1;
                ctl.bcond  = opcode[1:0];
                ctl.alu_op = ALU_SUB;
            end
            6'b001000, 6'b001001, 6'b001010, 6'b001011,
            6'b001100, 6'b001101, 6'b001110, 6'b001111: begin
                ctl.legal = 1'b1; ctl.we = 1'b1; ctl.dsel = DST_RT;
                ctl.src_imm = 1'b1;
                case (opcode[2:0])
                    3'b010:  ctl.alu_op = ALU_SLT;
                    3'b011:  ctl.alu_op = ALU_SLTU;
                    3'b100:  begin ctl.alu_op = ALU_AND;   imode = IMM_ZERO;  end
                    3'b101:  begin ctl.alu_op = ALU_OR;    imode = IMM_ZERO;  end
                    3'b110:  begin ctl.alu_op = ALU_XOR;   imode = IMM_ZERO;  end
                    3'b111:  begin ctl.alu_op = ALU_PASSB; imode = IMM_UPPER; end
                    default: ctl.alu_op = ALU_ADD;
                endcase
            end
            6'b100000, 6'b100001, 6'b100011, 6'b100100, 6'b100101: begin
                ctl.legal = 1'b1; ctl.we = 1'b1; ctl.dsel = DST_RT;
                ctl.src_imm = 1'b1; ctl.mem_rd = 1'b1;
                ctl.munsigned = opcode[2];
                ctl.msize = (opcode[1:0] == 2'b11) ? 2'd2 : {1'b0, opcode[0]};
            end
            6'b101000, 6'b101001, 6'b101011: begin
                ctl.legal = 1'b1; ctl.src_imm = 1'b1; ctl.mem_wr = 1'b1;
                ctl.msize = (opcode[1:0] == 2'b11) ? 2'd2 : {1'b0, opcode[0]};
            end
            default: ctl = ctl_idle();
        endcase
    end
endmodule

// File: rtl/idec_fn.sv
// Decodes the function field of register-format words (opcode 000000).
// Assumes the caller only uses the result when the opcode is 000000.
module idec_fn
    import idec_pkg::*;
(
    input  logic [5:0] funct,
    output ctl_t       ctl
);
    alu_op_e op;
    logic    hit;
    logic    sv;

    // Map each supported function code to an ALU operation.
    always_comb begin
        hit = 1'b1;
        sv  = 1'b0;
        op  = ALU_ADD;
        case (funct)
            6'b000000: op = ALU_SLL;
            6'b000010: op = ALU_SRL;
            6'b000011: op = ALU_SRA;
            6'b000100: begin op = ALU_SLL; sv = 1'b1; end
            6'b000110: begin op = ALU_SRL; sv = 1'b1; end
            6'b000111: begin op = ALU_SRA; sv = 1'b1; end
            6'b100000, 6'b100001: op = ALU_ADD;
            6'b100010, 6'b100011: op = ALU_SUB;
            6'b100100: op = ALU_AND;
            6'b100101: op = ALU_OR;
            6'b100110: op = ALU_XOR;
            6'b100111: op = ALU_NOR;
            6'b101010: op = ALU_SLT;
            6'b101011: op = ALU_SLTU;
            default:   hit = 1'b0;
        endcase
    end

    // Build the bundle: register jump, rd-writing operation, or illegal.
    always_comb begin
        ctl = ctl_idle();
        if (funct == 6'b001000) begin
            ctl.legal = 1'b1; ctl.jump = 1'b1; ctl.jreg = 1'b1;
        end else if (hit) begin
            ctl.legal = 1'b1; ctl.we = 1'b1; ctl.dsel = DST_RD;
            ctl.alu_op = op; ctl.shift_var = sv;
        end
    end
endmodule

// File: rtl/instr_decode.sv
// Decode stage: splits an instruction word into fields, derives control,
// picks the destination and registers the whole result once.
// Assumes a synchronous active-low reset that clears every output.
module instr_decode
    import idec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   instr,
    output logic [RW-1:0]   rs,
    output logic [RW-1:0]   rt,
    output logic [RW-1:0]   shamt,
    output logic [TGTW-1:0] target,
    output logic [IW-1:0]   imm,
    output logic [1:0]      fmt,
    output logic [RW-1:0]   dest,
    output logic            reg_we,
    output logic [ALUW-1:0] alu_op,
    output logic            alu_src_imm,
    output logic            shift_var,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [1:0]      mem_size,
    output logic            mem_unsigned,
    output logic            is_branch,
    output logic [1:0]      br_cond,
    output logic            is_jump,
    output logic            jump_reg,
    output logic            link,
    output logic            illegal
);
    typedef struct packed {
        logic [RW-1:0]   rs;
        logic [RW-1:0]   rt;
        logic [RW-1:0]   shamt;
        logic [TGTW-1:0] target;
        logic [IW-1:0]   imm;
        fmt_e            fmt;
        logic [RW-1:0]   dest;
        logic            we;
        ctl_t            ctl;
        logic            illegal;
    } dec_t;

    logic [OPW-1:0] opcode;
    logic [RW-1:0]  rd_f;
    ctl_t           opc_ctl, fn_ctl, sel_ctl;
    imm_e           imode;
    logic [IW-1:0]  imm_ext;
    logic [RW-1:0]  dst_reg;
    dec_t           nxt, q;

    assign opcode = instr[IW-1 -: OPW];
    assign rd_f   = instr[15:11];

    idec_opc u_opc (.opcode(opcode), .ctl(opc_ctl), .imode(imode));
    idec_fn  u_fn  (.funct(instr[5:0]), .ctl(fn_ctl));
    idec_imm u_imm (.raw(instr[IMMW-1:0]), .mode(imode), .ext(imm_ext));

    // Choose the bundle by format and resolve the destination register.
    always_comb begin
        sel_ctl = (opcode == OP_REG) ? fn_ctl : opc_ctl;
        case (sel_ctl.dsel)
            DST_RD:   dst_reg = rd_f;
            DST_RT:   dst_reg = instr[20:16];
            DST_LINK: dst_reg = LINK_REG;
            default:  dst_reg = '0;
        endcase
        nxt.rs      = instr[25:21];
        nxt.rt      = instr[20:16];
        nxt.shamt   = instr[10:6];
        nxt.target  = instr[TGTW-1:0];
        nxt.imm     = imm_ext;
        nxt.fmt     = (opcode == OP_REG) ? FMT_R :
                      (opcode[OPW-1:1] == 5'b00001) ? FMT_J : FMT_I;
        nxt.we      = sel_ctl.legal && sel_ctl.we && (dst_reg != '0);
        nxt.dest    = nxt.we ? dst_reg : '0;
        nxt.ctl     = sel_ctl;
        nxt.illegal = !sel_ctl.legal;
    end

    // Decode-stage register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign rs           = q.rs;
    assign rt           = q.rt;
    assign shamt        = q.shamt;
    assign target       = q.target;
    assign imm          = q.imm;
    assign fmt          = q.fmt;
    assign dest         = q.dest;
    assign reg_we       = q.we;
    assign alu_op       = q.ctl.alu_op;
    assign alu_src_imm  = q.ctl.src_imm;
    assign shift_var    = q.ctl.shift_var;
    assign mem_rd       = q.ctl.mem_rd;
    assign mem_wr       = q.ctl.mem_wr;
    assign mem_size     = q.ctl.msize;
    assign mem_unsigned = q.ctl.munsigned;
    assign is_branch    = q.ctl.branch;
    assign br_cond      = q.ctl.bcond;
    assign is_jump      = q.ctl.jump;
    assign jump_reg     = q.ctl.jreg;
    assign link         = q.ctl.link;
    assign illegal      = q.illegal;
endmodule

// File: rtl/idec_chk.sv
// Property checker for the decoder, attached to every instance by bind.
// Assumes the port names of instr_decode.
module idec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr,
    input logic [4:0]  dest,
    input logic        reg_we,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        is_branch,
    input logic        is_jump,
    input logic        link,
    input logic        illegal
);
    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(reg_we || mem_rd || mem_wr || is_branch || is_jump || link));

    a_r11_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (dest != 5'd0));

    a_r8_one_mem_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r8_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !reg_we);

    a_r10_link_to_r31: assert property (@(posedge clk) disable iff (!rst_n)
        link |-> (reg_we && dest == 5'd31));

    a_r1_word_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[31:26] == 6'b100011 && instr[20:16] != 5'd0)
        |=> (mem_rd && reg_we && dest == $past(instr[20:16])));
endmodule

bind instr_decode idec_chk i_chk (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dest(dest), .reg_we(reg_we),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .is_branch(is_branch),
    .is_jump(is_jump), .link(link), .illegal(illegal)
);

// File: tb/test_instr_decode.sv
module test_instr_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'hFFFF_FFFF;
    logic [4:0]  rs, rt, shamt, dest;
    logic [25:0] target;
    logic [31:0] imm;
    logic [1:0]  fmt, mem_size, br_cond;
    logic [3:0]  alu_op;
    logic reg_we, alu_src_imm, shift_var, mem_rd, mem_wr, mem_unsigned;
    logic is_branch, is_jump, jump_reg, link, illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    instr_decode i_instr_decode (
        .clk(clk), .rst_n(rst_n), .instr(instr), .rs(rs), .rt(rt),
        .shamt(shamt), .target(target), .imm(imm), .fmt(fmt), .dest(dest),
        .reg_we(reg_we), .alu_op(alu_op), .alu_src_imm(alu_src_imm),
        .shift_var(shift_var), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_size(mem_size), .mem_unsigned(mem_unsigned),
        .is_branch(is_branch), .br_cond(br_cond), .is_jump(is_jump),
        .jump_reg(jump_reg), .link(link), .illegal(illegal)
    );

    // Expected control fields, filled by predict().
    logic [3:0] e_alu;
    logic [1:0] e_fmt, e_msz, e_bc, e_dsel;
    logic [4:0] e_dest;
    logic [31:0] e_imm;
    logic e_we, e_src, e_sv, e_rd, e_wr, e_un, e_br, e_jp, e_jr, e_lk, e_legal;
    logic [4:0] e_nom;
    string e_tag;

    function automatic logic [23:0] ctl_act();
        return {reg_we, dest, alu_op, alu_src_imm, shift_var, mem_rd, mem_wr,
                mem_size, mem_unsigned, is_branch, br_cond, is_jump, jump_reg,
                link, illegal};
    endfunction

    function automatic logic [23:0] ctl_exp();
        return {e_we, e_dest, e_alu, e_src, e_sv, e_rd, e_wr, e_msz, e_un,
                e_br, e_bc, e_jp, e_jr, e_lk, !e_legal};
    endfunction

    task automatic check(input string tag, input logic [63:0] act,
                         input logic [63:0] exp, input logic [31:0] w);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s word=%h actual=%h expected=%h", tag, w, act, exp);
        end
    endtask

    // Reference decode written from the requirement list.
    task automatic predict(input logic [31:0] w);
        logic [5:0] op, fn;
        op = w[31:26]; fn = w[5:0];
        e_alu = 4'd0; e_src = 0; e_sv = 0; e_rd = 0; e_wr = 0; e_msz = 0;
        e_un = 0; e_br = 0; e_bc = 0; e_jp = 0; e_jr = 0; e_lk = 0;
        e_legal = 0; e_dsel = 0; e_tag = "R12";
        e_fmt = (op == 0) ? 2'd0 : (op == 6'd2 || op == 6'd3) ? 2'd2 : 2'd1;   // R3
        e_imm = {{16{w[15]}}, w[15:0]};                                         // R6
        if (op == 6'h0C || op == 6'h0D || op == 6'h0E) e_imm = {16'h0, w[15:0]};
        if (op == 6'h0F) e_imm = {w[15:0], 16'h0};
        if (op == 0) begin
            e_legal = 1; e_dsel = 1; e_tag = "R4";
            case (fn)
                6'h00: begin e_alu = 8;  e_tag = "R5"; end
                6'h02: begin e_alu = 9;  e_tag = "R5"; end
                6'h03: begin e_alu = 10; e_tag = "R5"; end
                6'h04: begin e_alu = 8;  e_sv = 1; e_tag = "R5"; end
                6'h06: begin e_alu = 9;  e_sv = 1; e_tag = "R5"; end
                6'h07: begin e_alu = 10; e_sv = 1; e_tag = "R5"; end
                6'h08: begin e_dsel = 0; e_jp = 1; e_jr = 1; e_tag = "R10"; end
                6'h20, 6'h21: e_alu = 0;
                6'h22, 6'h23: e_alu = 1;
                6'h24: e_alu = 2;
                6'h25: e_alu = 3;
                6'h26: e_alu = 4;
                6'h27: e_alu = 5;
                6'h2A: e_alu = 6;
                6'h2B: e_alu = 7;
                default: begin e_legal = 0; e_dsel = 0; e_tag = "R12"; end
            endcase
        end else if (op == 6'h02) begin
            e_legal = 1; e_jp = 1; e_tag = "R10";
        end else if (op == 6'h03) begin
            e_legal = 1; e_jp = 1; e_lk = 1; e_dsel = 3; e_tag = "R10";
        end else if (op >= 6'h04 && op <= 6'h07) begin
            e_legal = 1; e_br = 1; e_bc = 2'(op - 6'h04); e_alu = 1; e_tag = "R9";
        end else if (op >= 6'h08 && op <= 6'h0F) begin
            e_legal = 1; e_dsel = 2; e_src = 1; e_tag = "R7";
            case (op)
                6'h0A: e_alu = 6;
                6'h0B: e_alu = 7;
                6'h0C: e_alu = 2;
                6'h0D: e_alu = 3;
                6'h0E: e_alu = 4;
                6'h0F: e_alu = 11;
                default: e_alu = 0;
            endcase
        end else if (op == 6'h20 || op == 6'h21 || op == 6'h23 || op == 6'h24 || op == 6'h25) begin
            e_legal = 1; e_dsel = 2; e_src = 1; e_rd = 1; e_tag = "R8";
            e_msz = (op == 6'h23) ? 2'd2 : (op == 6'h21 || op == 6'h25) ? 2'd1 : 2'd0;
            e_un  = (op == 6'h24 || op == 6'h25);
        end else if (op == 6'h28 || op == 6'h29 || op == 6'h2B) begin
            e_legal = 1; e_src = 1; e_wr = 1; e_tag = "R8";
            e_msz = (op == 6'h2B) ? 2'd2 : (op == 6'h29) ? 2'd1 : 2'd0;
        end
        case (e_dsel)
            2'd1: e_nom = w[15:11];
            2'd2: e_nom = w[20:16];
            2'd3: e_nom = 5'd31;
            default: e_nom = 5'd0;
        endcase
        e_we = (e_dsel != 0) && (e_nom != 0);
        e_dest = e_we ? e_nom : 5'd0;
        if (e_dsel != 0 && e_nom == 0) e_tag = "R11";
    endtask

    // Present a word, wait for the registering edge, compare away from it.
    task automatic apply(input logic [31:0] w);
        instr = w;
        @(posedge clk);
        #2;
        predict(w);
        check("R2", 64'({rs, rt, shamt, target}),
              64'({w[25:21], w[20:16], w[10:6], w[25:0]}), w);
        check("R3", 64'(fmt), 64'(e_fmt), w);
        check("R6", 64'(imm), 64'(e_imm), w);
        check(e_tag, 64'(ctl_act()), 64'(ctl_exp()), w);
    endtask

    function automatic logic [31:0] make_word(input int op, input int fn, input int v);
        logic [4:0] f_rs, f_rt, f_rd, f_sh;
        f_rs = 5'(op * 3 + v * 7 + 1);
        f_rt = (v == 1) ? 5'd0 : 5'(op + v * 5 + 2);
        f_rd = (v == 2) ? 5'd0 : {v[0], 4'(op + fn + v + 3)};
        f_sh = 5'(v * 9 + op + fn);
        return {6'(op), f_rs, f_rt, f_rd, f_sh, 6'(fn)};
    endfunction

    initial begin
        // R1: outputs are all zero under reset
        repeat (3) @(posedge clk);
        #2;
        check("R1", 64'({ctl_act(), rs, rt, shamt}), 64'(0), instr);
        check("R1", 64'({target, imm, fmt}), 64'(0), instr);
        rst_n = 1'b1;
        // R1: a word appears one edge after it is presented
        instr = {6'h23, 5'd4, 5'd9, 16'h0010};
        @(posedge clk);
        #2;
        check("R1", 64'({mem_rd, reg_we, dest}), 64'({1'b1, 1'b1, 5'd9}), instr);
        for (int op = 1; op < 64; op++)
            for (int v = 0; v < 4; v++)
                apply(make_word(op, op * 7 + v, v));
        for (int fn = 0; fn < 64; fn++)
            for (int v = 0; v < 4; v++)
                apply(make_word(0, fn, v));
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule